// File: doc/BRIEF.md
# Processor halt and step controller

This block decides when a processor core leaves normal execution and enters a halted debug state, and when it comes back out. A debug probe writes a single control word. The write is accepted only when the upper half of the word carries a fixed key. The low bits of that word hold a debug enable, a halt request, a single-step request and an interrupt mask. The core reports instruction boundaries and retired instructions. Breakpoint or watchpoint comparators and fault escalation logic give the other halt causes.

At an instruction boundary the controller checks whether the core may be halted in its present security state. If it may, a pending halt cause moves the controller into the halted state. The controller then drives a halt signal to the pipeline and a freeze signal to timers and the watchdog. From the halted state, a keyed write can resume execution or run exactly one instruction. After that instruction the controller returns to the halted state. Interrupts can be held off for as long as the core is not freely running. The control word can be read back together with status bits for halted, stepping and the cause of the last halt.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write changes the control bits only when `wr_data_i[31:16]` equals 16'hA05F. A write with any other upper half leaves `rd_data_o[3:0]` and the halt state unchanged.
- R2: An accepted write stores bit 0 as debug enable, bit 1 as halt request, bit 2 as step and bit 3 as interrupt mask. These four bits read back on `rd_data_o[3:0]`, and `rd_data_o[31:19]` and `rd_data_o[15:4]` read zero.
- R3: A halt cause (a stored halt request, `bkpt_hit_i` or `fault_esc_i`) is acted on only in a cycle with `boundary_i` high. `halt_o` rises on the clock edge that samples that boundary.
- R4: While debug enable is 0, no halt cause halts the core.
- R5: `rd_data_o[16]` reads 1 while halted. `rd_data_o[17]` reads 1 when the current halt was entered with `bkpt_hit_i` high, and it reads 0 after any exit from the halted state. `rd_data_o[18]` reads 1 while a step is in progress.
- R6: When `secure_i` is 1, halting and stepping are permitted only if `sec_dbg_en_i` is 1. When `secure_i` is 0, they are permitted only if `nsec_dbg_en_i` is 1, whatever the value of `sec_dbg_en_i`.
- R7: While halted, an accepted write with bit 2 set (for example 32'hA05F000D) drops `halt_o`. `halt_o` then returns high on the edge that samples `retire_i` high, and stays low until that edge.
- R8: While halted, an accepted write with bits 2 and 1 both clear (for example 32'hA05F0001) resumes execution. A write with bit 1 set and bit 2 clear keeps the core halted.
- R9: `irq_mask_o` is 1 only while halted or stepping with the stored mask bit set. It is 0 whenever the core is running.
- R10: With parameter `FREEZE_EN` = 1, `freeze_o` equals the halted state. With `FREEZE_EN` = 0, `freeze_o` is tied to 0.
- R11: `dbg_gate_s_o` equals debug enable AND `sec_dbg_en_i`. `dbg_gate_ns_o` equals debug enable AND `nsec_dbg_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data, key in the upper half |
| rd_data_o | output | 32 | Control bits and status readback |
| boundary_i | input | 1 | Core is at an instruction boundary |
| retire_i | input | 1 | Core retired an instruction |
| bkpt_hit_i | input | 1 | Breakpoint or watchpoint match |
| fault_esc_i | input | 1 | Fault escalated towards debug |
| secure_i | input | 1 | Core is executing secure code |
| sec_dbg_en_i | input | 1 | Secure debug permitted |
| nsec_dbg_en_i | input | 1 | Non-secure debug permitted |
| halt_o | output | 1 | Halt the pipeline |
| irq_mask_o | output | 1 | Hold off interrupts |
| freeze_o | output | 1 | Freeze timers and watchdog |
| dbg_gate_s_o | output | 1 | Secure-state debug permission |
| dbg_gate_ns_o | output | 1 | Non-secure-state debug permission |

## Verification
The bench builds the block with its defaults: a 32-bit word, the 16-bit key and the freeze output enabled. With these values the bench can sweep every combination of debug enable, security state and the two security enables, for each of the three halt causes. In each case it checks the halt, freeze, cause and gate outputs against an expected value worked out from the permission rule. The bench also flips each bit of the key one at a time. It walks the step handshake with and without masking, and it refuses a secure step.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STEP = 2'd2
    } run_st_e;

    typedef struct packed {
        logic maskint;
        logic step;
        logic haltreq;
        logic dbgen;
    } ctrl_t;

    typedef struct packed {
        run_st_e st;
        logic    cause_bkpt;
    } fsm_t;

    localparam int CTRL_W = 4;
    localparam int STAT_HALTED = 0;
    localparam int STAT_CAUSE  = 1;
    localparam int STAT_STEP   = 2;
    localparam int STAT_W      = 3;

endpackage

// File: rtl/dbg_key_check.sv
module dbg_key_check #(
    parameter int          DATA_W = 32,
    parameter int          KEY_W  = DATA_W / 2,
    parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
    input  logic                        wr_en_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic                        accept_o,
    output dbg_halt_pkg::ctrl_t         ctrl_o
);
    logic [DATA_W-KEY_W-1:0] unused_payload;

    // Only the key half gates acceptance; the payload carries the fields.
    assign accept_o = wr_en_i && (wr_data_i[DATA_W-1:KEY_W] == KEY);
    assign ctrl_o   = dbg_halt_pkg::ctrl_t'(wr_data_i[dbg_halt_pkg::CTRL_W-1:0]);
    assign unused_payload = wr_data_i[DATA_W-KEY_W-1:0];
endmodule

// File: rtl/dbg_perm_gate.sv
module dbg_perm_gate (
    input  logic dbgen_i,
    input  logic secure_i,
    input  logic sec_en_i,
    input  logic nsec_en_i,
    output logic allow_o,
    output logic gate_s_o,
    output logic gate_ns_o
);
    assign gate_s_o  = dbgen_i & sec_en_i;
    assign gate_ns_o = dbgen_i & nsec_en_i;
    // Permission follows the security state the core is in right now.
    assign allow_o   = secure_i ? gate_s_o : gate_ns_o;
endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
    import dbg_halt_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    accept_i,
    input  ctrl_t   wr_ctrl_i,
    input  logic    haltreq_i,
    input  logic    allow_i,
    input  logic    boundary_i,
    input  logic    bkpt_i,
    input  logic    fault_i,
    input  logic    retire_i,
    output run_st_e st_o,
    output logic    cause_bkpt_o
);
    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_RUN: begin
                if (boundary_i && allow_i && (haltreq_i || bkpt_i || fault_i)) begin
                    fsm_d.st         = ST_HALT;
                    fsm_d.cause_bkpt = bkpt_i;
                end
            end
            ST_HALT: begin
                if (accept_i) begin
                    if (wr_ctrl_i.step) begin
                        if (allow_i) begin
                            fsm_d.st         = ST_STEP;
                            fsm_d.cause_bkpt = 1'b0;
                        end
                    end else if (!wr_ctrl_i.haltreq) begin
                        fsm_d.st         = ST_RUN;
                        fsm_d.cause_bkpt = 1'b0;
                    end
                end
            end
            ST_STEP: begin
                if (retire_i) begin
                    fsm_d.st = ST_HALT;
                end
            end
            default: begin
                fsm_d.st         = ST_RUN;
                fsm_d.cause_bkpt = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{st: ST_RUN, cause_bkpt: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign st_o         = fsm_q.st;
    assign cause_bkpt_o = fsm_q.cause_bkpt;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [15:0] KEY       = 16'hA05F,
    parameter bit          FREEZE_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              boundary_i,
    input  logic              retire_i,
    input  logic              bkpt_hit_i,
    input  logic              fault_esc_i,
    input  logic              secure_i,
    input  logic              sec_dbg_en_i,
    input  logic              nsec_dbg_en_i,
    output logic              halt_o,
    output logic              irq_mask_o,
    output logic              freeze_o,
    output logic              dbg_gate_s_o,
    output logic              dbg_gate_ns_o
);
    localparam int KEY_W = DATA_W / 2;

    logic    accept;
    ctrl_t   wr_ctrl;
    ctrl_t   ctrl_d, ctrl_q;
    logic    allow;
    run_st_e st;
    logic    cause_bkpt;
    logic    halted, stepping;

    dbg_key_check #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY    (KEY)
    ) u_key (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .accept_o  (accept),
        .ctrl_o    (wr_ctrl)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (accept) begin
            ctrl_d = wr_ctrl;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    dbg_perm_gate u_perm (
        .dbgen_i   (ctrl_q.dbgen),
        .secure_i  (secure_i),
        .sec_en_i  (sec_dbg_en_i),
        .nsec_en_i (nsec_dbg_en_i),
        .allow_o   (allow),
        .gate_s_o  (dbg_gate_s_o),
        .gate_ns_o (dbg_gate_ns_o)
    );

    dbg_run_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .accept_i     (accept),
        .wr_ctrl_i    (wr_ctrl),
        .haltreq_i    (ctrl_q.haltreq),
        .allow_i      (allow),
        .boundary_i   (boundary_i),
        .bkpt_i       (bkpt_hit_i),
        .fault_i      (fault_esc_i),
        .retire_i     (retire_i),
        .st_o         (st),
        .cause_bkpt_o (cause_bkpt)
    );

    assign halted     = (st == ST_HALT);
    assign stepping   = (st == ST_STEP);
    assign halt_o     = halted;
    assign irq_mask_o = ctrl_q.maskint & (halted | stepping);

    generate
        if (FREEZE_EN) begin : g_freeze
            assign freeze_o = halted;
        end else begin : g_no_freeze
            assign freeze_o = 1'b0;
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        rd_data_o[CTRL_W-1:0]          = ctrl_q;
        rd_data_o[KEY_W+STAT_HALTED]   = halted;
        rd_data_o[KEY_W+STAT_CAUSE]    = cause_bkpt;
        rd_data_o[KEY_W+STAT_STEP]     = stepping;
    end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
    parameter int          DATA_W = 32,
    parameter logic [15:0] KEY    = 16'hA05F
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              boundary_i,
    input logic              retire_i,
    input logic              secure_i,
    input logic              sec_dbg_en_i,
    input logic              halt_o,
    input logic              irq_mask_o,
    input logic              freeze_o
);
    localparam int KEY_W = DATA_W / 2;

    logic running;
    assign running = !halt_o && !rd_data_o[KEY_W+2];

    AST_KEY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[DATA_W-1:KEY_W] != KEY) |=> $stable(rd_data_o[3:0])); // R1

    AST_NO_HALT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !rd_data_o[0]) |=> !halt_o); // R4

    AST_BOUNDARY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !boundary_i) |=> !halt_o); // R3

    AST_CAUSE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(halt_o) |-> !rd_data_o[KEY_W+1]); // R5

    AST_SECURE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && boundary_i && secure_i && !sec_dbg_en_i) |=> !halt_o); // R6

    AST_STEP_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[KEY_W+2] && retire_i) |=> halt_o); // R7

    AST_MASK_NOT_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_mask_o |-> !running); // R9

    AST_FREEZE_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_o |-> halt_o); // R10
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(
    .DATA_W (DATA_W),
    .KEY    (KEY)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .boundary_i   (boundary_i),
    .retire_i     (retire_i),
    .secure_i     (secure_i),
    .sec_dbg_en_i (sec_dbg_en_i),
    .halt_o       (halt_o),
    .irq_mask_o   (irq_mask_o),
    .freeze_o     (freeze_o)
);

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;
    localparam logic [15:0] KEY = 16'hA05F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        boundary = 1'b0, retire = 1'b0, bkpt = 1'b0, fault = 1'b0;
    logic        secure = 1'b0, sen = 1'b0, nsen = 1'b1;
    logic        halt, mask, freeze, gate_s, gate_ns;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dbg_halt_ctrl uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .boundary_i    (boundary),
        .retire_i      (retire),
        .bkpt_hit_i    (bkpt),
        .fault_esc_i   (fault),
        .secure_i      (secure),
        .sec_dbg_en_i  (sen),
        .nsec_dbg_en_i (nsen),
        .halt_o        (halt),
        .irq_mask_o    (mask),
        .freeze_o      (freeze),
        .dbg_gate_s_o  (gate_s),
        .dbg_gate_ns_o (gate_ns)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0; boundary = 1'b0; retire = 1'b0; bkpt = 1'b0; fault = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] key, input logic [15:0] low);
        @(negedge clk);
        wr_en = 1'b1; wr_data = {key, low};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic b, input logic bk, input logic ft, input logic rt);
        @(negedge clk);
        boundary = b; bkpt = bk; fault = ft; retire = rt;
        @(negedge clk);
        boundary = 1'b0; bkpt = 1'b0; fault = 1'b0; retire = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Reset state
        chk(rd_data, 32'h0, "R2 reset readback");
        chk(halt, 0, "R5 reset halt");
        chk(freeze, 0, "R10 reset freeze");
        chk(mask, 0, "R9 reset mask");

        // R1: every single-bit key corruption, plus all-zero and all-one keys
        for (int i = 0; i < 18; i++) begin
            logic [15:0] bad;
            bad = (i < 16) ? (KEY ^ (16'h1 << i)) : ((i == 16) ? 16'h0000 : 16'hFFFF);
            wr(bad, 16'h000F);
            chk(rd_data[3:0], 4'h0, "R1 bad key ignored");
            chk(halt, 0, "R1 bad key no halt");
        end

        // R2: field layout and readback
        wr(KEY, 16'h000D);
        chk(rd_data, 32'h0000000D, "R2 readback 0xD");
        wr(KEY, 16'h0001);
        chk(rd_data, 32'h00000001, "R2 readback 0x1");
        wr(KEY, 16'hFFF0);
        chk(rd_data, 32'h00000000, "R2 upper payload bits read zero");

        // R3: halt request pends until a boundary
        wr(KEY, 16'h0003);
        repeat (4) @(negedge clk);
        chk(halt, 0, "R3 no boundary no halt");
        pulse(0, 1, 1, 0);
        chk(halt, 0, "R3 events without boundary");
        pulse(1, 0, 0, 0);
        chk(halt, 1, "R3 halt at boundary");
        // R8: halt bit still set keeps halted
        wr(KEY, 16'h0003);
        chk(halt, 1, "R8 halt bit keeps halted");
        wr(KEY, 16'h0001);
        chk(halt, 0, "R8 resume");

        // Sweep: cause x dbgen x security state x enables (R4 R5 R6 R10 R11)
        for (int src = 0; src < 3; src++) begin
            for (int c = 0; c < 16; c++) begin
                logic de, ss, se, ne, exp;
                de = c[0]; ss = c[1]; se = c[2]; ne = c[3];
                exp = de & (ss ? se : ne);
                do_reset();
                secure = ss; sen = se; nsen = ne;
                wr(KEY, {14'h0, (src == 0), de});
                chk(gate_s, de & se, "R11 secure gate");
                chk(gate_ns, de & ne, "R11 non-secure gate");
                pulse(1, src == 1, src == 2, 0);
                chk(halt, exp, "R4 R6 halt decision");
                chk(rd_data[16], exp, "R5 halted status");
                chk(rd_data[17], exp & (src == 1), "R5 cause bit");
                chk(freeze, exp, "R10 freeze follows halt");
                if (exp) begin
                    wr(KEY, 16'h0001);
                    chk(halt, 0, "R8 resume after sweep halt");
                    chk(rd_data[17], 0, "R5 cause cleared on resume");
                end
            end
        end

        // R7 R9: step with masking
        do_reset();
        secure = 0; sen = 0; nsen = 1;
        wr(KEY, 16'h0003);
        pulse(1, 1, 0, 0);
        chk(rd_data[17], 1, "R5 breakpoint cause");
        wr(KEY, 16'h000D);
        chk(halt, 0, "R7 step releases halt");
        chk(mask, 1, "R9 mask during step");
        chk(rd_data[18], 1, "R5 stepping status");
        chk(rd_data[17], 0, "R5 cause cleared on step");
        repeat (3) @(negedge clk);
        chk(halt, 0, "R7 waits for retire");
        pulse(0, 0, 0, 1);
        chk(halt, 1, "R7 halted after retire");
        chk(mask, 1, "R9 mask while halted");
        chk(rd_data[18], 0, "R5 step done");
        wr(KEY, 16'h0001);
        chk(halt, 0, "R8 run after step");
        chk(mask, 0, "R9 mask off when running");

        // R9: step without masking
        wr(KEY, 16'h0003);
        pulse(1, 0, 0, 0);
        wr(KEY, 16'h0005);
        chk(mask, 0, "R9 no mask requested");
        chk(halt, 0, "R7 unmasked step");
        pulse(0, 0, 0, 1);
        chk(halt, 1, "R7 unmasked step returns");
        chk(freeze, 1, "R10 freeze after step");

        // R6: step refused in secure state without secure enable
        secure = 1; sen = 0; nsen = 1;
        wr(KEY, 16'h0005);
        chk(halt, 1, "R6 secure step refused");
        chk(rd_data[18], 0, "R6 no stepping");
        wr(KEY, 16'h0001);
        chk(halt, 0, "R8 resume from secure");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule